// File: doc/BRIEF.md
# Serial Two-Wire Register Access Slave

This block is a two-wire bus slave that lets an external host read and write a small bank of 8-bit control registers. It runs entirely on the system clock and treats SCL and SDA as slow asynchronous inputs. Each line is synchronised and passed through a pulse-rejection filter. START, repeated START and STOP are decoded from the filtered lines, and bytes are framed and acknowledged. The SDA output is an open-drain enable: when high, the pad pulls the line low.

A transaction opens with an identification byte. Its upper five bits are a fixed prefix, the next two bits come from two strap pins, and the last bit selects the direction. A write carries a register address and one data byte, and the data is committed during the acknowledge clock of that data byte. A read first sets the address with a write-direction header, then uses a repeated START and a read-direction identification byte. The slave then returns the selected register until the host declines a byte. The register bank itself lives outside the block. The block offers it a one-cycle write strobe, an address, write data and a read-data input, and it decodes which of two register addresses exist.

For a window after reset the slave ignores the bus, so a START seen during power-up has no effect.

Top module: `i2c_regport`

## Requirements
- R1: After reset `sda_oe_o` and `reg_wr_en_o` are 0. A START that occurs within `PWRUP_CYCLES` clock cycles after reset is ignored: the identification byte that follows gets no ACK, and nothing is written.
- R2: Once synchronised, a pulse on SCL or SDA that lasts fewer than `FILT_CYCLES` system clocks is suppressed and has no effect on framing.
- R3: The identification byte is received MSB first. Bits 7..3 equal 10100, bit 2 equals `strap_i[1]`, bit 1 equals `strap_i[0]`, and bit 0 is the direction (1 = read, 0 = write). On a match the slave holds SDA low (`sda_oe_o`=1) during the ninth SCL clock.
- R4: An identification byte that does not match gets no ACK. No later byte is ACKed until the next START.
- R5: A write consists of START, identification byte (write), address byte, data byte; each byte is ACKed. `reg_wr_en_o` pulses for exactly one cycle while SCL is high in the ninth clock of the data byte, with `reg_addr_o` = address and `reg_wdata_o` = data.
- R6: Only addresses 00h and 10h are mapped. A write to any other address is ACKed on all three bytes, but no write strobe is produced.
- R7: A read consists of START, identification byte (write), address byte, repeated START, identification byte (read). The slave then sends `reg_rdata_i` for the addressed register MSB first. It sends one more byte each time the host ACKs, repeats the same register every time, and releases SDA once the host NACKs.
- R8: A read from an unmapped address returns 00h whatever `reg_rdata_i` holds.
- R9: `sda_oe_o` changes only while SCL is low.
- R10: A STOP returns the slave to idle with SDA released. Bytes clocked after a STOP and before a new START are not ACKed.
- R11: In a write, any byte after the single data byte gets no ACK and produces no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sensed at the pad |
| sda_i | input | 1 | Bus data line as sensed at the pad |
| strap_i | input | 2 | Strap pins giving identification bits 2 and 1 |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| reg_wr_en_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | 8 | Register address for write and read mux |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Read data from the register bank for `reg_addr_o` |

## Verification
The bench builds the block with `SYNC_STAGES`=2, `FILT_CYCLES`=3 and `PWRUP_CYCLES`=40. With that short power-up window, a START issued straight after reset falls inside the ignore period. Three filter cycles let a two-cycle SCL spike be injected in the middle of a data byte to show it adds no bit. The bus quarter-period of 12 clocks is long enough to cover the synchroniser and filter latency, so the exact acknowledge window and the commit of the write strobe can both be observed. The bench register model returns 5Ah for unmapped addresses, which makes the forced 00h read visible.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  localparam int BYTE_W    = 8;
  localparam int BITCNT_W  = 4;
  localparam logic [4:0] ID_PREFIX_DEF = 5'b10100;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ID,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2cr_line_filter.sv
module i2cr_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_s;
  logic [CW-1:0]          cnt_q;

  assign sync_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= (sync_q << 1) | SYNC_STAGES'(line_i);
  end

  // output follows the synchronised line only after it has differed
  // for FILT_CYCLES consecutive clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else if (sync_s == line_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
      line_o <= sync_s;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  if (FILT_CYCLES >= 2) begin : g_chk
    assert_filter_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !$stable(line_o) |-> ($past(sync_s) == line_o && $past(sync_s, 2) == line_o));
  end
endmodule

// File: rtl/i2cr_bus_cond.sv
module i2cr_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/i2cr_powerup_gate.sv
module i2cr_powerup_gate #(
  parameter int PWRUP_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic ready_o
);
  localparam int CW = ($clog2(PWRUP_CYCLES + 1) < 1) ? 1 : $clog2(PWRUP_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else if (cnt_q == CW'(PWRUP_CYCLES)) begin
      ready_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_CYCLES  = 3,
  parameter int PWRUP_CYCLES = 1000,
  parameter logic [BYTE_W-1:0] WIPER_ADDR = 8'h00,
  parameter logic [BYTE_W-1:0] CTRL_ADDR  = 8'h10,
  parameter logic [4:0] ID_PREFIX = ID_PREFIX_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_i,
  output logic              sda_oe_o,
  output logic              reg_wr_en_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int NLINES = 2;
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);

  logic [NLINES-1:0] raw_w, filt_w;
  logic scl_f, sda_f;
  logic start_w, stop_w, rise_w, fall_w, ready_w;

  assign raw_w = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2cr_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYCLES(FILT_CYCLES)
    ) u_filt (
      .clk   (clk),
      .rst   (rst),
      .line_i(raw_w[g]),
      .line_o(filt_w[g])
    );
  end

  assign scl_f = filt_w[1];
  assign sda_f = filt_w[0];

  i2cr_bus_cond u_cond (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_f),
    .sda_i  (sda_f),
    .start_o(start_w),
    .stop_o (stop_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  i2cr_powerup_gate #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_pwr (
    .clk    (clk),
    .rst    (rst),
    .ready_o(ready_w)
  );

  phase_t              phase_q;
  logic [BITCNT_W-1:0] bitcnt_q;
  logic                in_ack_q, rw_q, nack_q, wr_en_q, sda_oe_q;
  logic [BYTE_W-1:0]   shreg_q, tx_q, addr_q, wdata_q;
  logic                addr_hit;
  logic [BYTE_W-1:0]   rd_mux;
  logic                rx_phase;

  assign addr_hit = (addr_q == WIPER_ADDR) || (addr_q == CTRL_ADDR);
  assign rd_mux   = addr_hit ? reg_rdata_i : '0;
  assign rx_phase = (phase_q == PH_ID) || (phase_q == PH_ADDR) || (phase_q == PH_WDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      bitcnt_q <= '0;
      in_ack_q <= 1'b0;
      rw_q     <= 1'b0;
      nack_q   <= 1'b0;
      wr_en_q  <= 1'b0;
      sda_oe_q <= 1'b0;
      shreg_q  <= '0;
      tx_q     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_w && ready_w) begin
        phase_q  <= PH_ID;
        bitcnt_q <= '0;
        in_ack_q <= 1'b0;
        sda_oe_q <= 1'b0;
      end else if (stop_w) begin
        phase_q  <= PH_IDLE;
        in_ack_q <= 1'b0;
        sda_oe_q <= 1'b0;
      end else if (rx_phase && !in_ack_q) begin
        // receiving eight bits, sampled on SCL rise
        if (rise_w && bitcnt_q < LAST_BIT) begin
          shreg_q  <= {shreg_q[BYTE_W-2:0], sda_f};
          bitcnt_q <= bitcnt_q + 1'b1;
        end else if (fall_w && bitcnt_q == LAST_BIT) begin
          case (phase_q)
            PH_ID: begin
              if (shreg_q[BYTE_W-1:1] == {ID_PREFIX, strap_i}) begin
                rw_q     <= shreg_q[0];
                sda_oe_q <= 1'b1;
                in_ack_q <= 1'b1;
              end else begin
                phase_q <= PH_SKIP;
              end
            end
            PH_ADDR: begin
              addr_q   <= shreg_q;
              sda_oe_q <= 1'b1;
              in_ack_q <= 1'b1;
            end
            default: begin
              wdata_q  <= shreg_q;
              sda_oe_q <= 1'b1;
              in_ack_q <= 1'b1;
            end
          endcase
        end
      end else if (rx_phase) begin
        // slave acknowledge clock
        if (rise_w && phase_q == PH_WDATA && addr_hit) begin
          wr_en_q <= 1'b1;
        end else if (fall_w) begin
          in_ack_q <= 1'b0;
          bitcnt_q <= '0;
          case (phase_q)
            PH_ID: begin
              if (rw_q) begin
                phase_q  <= PH_RDATA;
                tx_q     <= rd_mux;
                sda_oe_q <= ~rd_mux[BYTE_W-1];
              end else begin
                phase_q  <= PH_ADDR;
                sda_oe_q <= 1'b0;
              end
            end
            PH_ADDR: begin
              phase_q  <= PH_WDATA;
              sda_oe_q <= 1'b0;
            end
            default: begin
              phase_q  <= PH_SKIP;
              sda_oe_q <= 1'b0;
            end
          endcase
        end
      end else if (phase_q == PH_RDATA && !in_ack_q) begin
        // transmitting, next bit placed after each SCL fall
        if (rise_w) begin
          bitcnt_q <= bitcnt_q + 1'b1;
        end else if (fall_w && bitcnt_q == LAST_BIT) begin
          sda_oe_q <= 1'b0;
          in_ack_q <= 1'b1;
        end else if (fall_w && bitcnt_q != '0) begin
          tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
          sda_oe_q <= ~tx_q[BYTE_W-2];
        end
      end else if (phase_q == PH_RDATA) begin
        // host acknowledge clock
        if (rise_w) begin
          nack_q <= sda_f;
        end else if (fall_w) begin
          in_ack_q <= 1'b0;
          bitcnt_q <= '0;
          if (nack_q) begin
            phase_q  <= PH_SKIP;
            sda_oe_q <= 1'b0;
          end else begin
            tx_q     <= rd_mux;
            sda_oe_q <= ~rd_mux[BYTE_W-1];
          end
        end
      end
    end
  end

  assign sda_oe_o    = sda_oe_q;
  assign reg_wr_en_o = wr_en_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;

  assert_quiet_powerup_R1: assert property (@(posedge clk) disable iff (rst)
    !ready_w |-> (phase_q == PH_IDLE && !sda_oe_o));

  assert_skip_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SKIP) |-> !sda_oe_o);

  assert_wr_single_R5: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en_o |=> !reg_wr_en_o);

  assert_wr_mapped_R6: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en_o |-> (reg_addr_o == WIPER_ADDR || reg_addr_o == CTRL_ADDR));

  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> (!$past(scl_f) || $past(start_w) || $past(stop_w)));

  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (rst)
    stop_w |=> (phase_q == PH_IDLE && !sda_oe_o));
endmodule

// File: tb/i2c_regport_tb_top.sv
`timescale 1ns/1ps
module i2c_regport_tb_top;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap = 2'b01;
  logic sda_oe, wr_en;
  logic [7:0] addr, wdata, rdata;
  logic sda_line;
  assign sda_line = m_sda & ~sda_oe;

  i2c_regport #(
    .SYNC_STAGES(2),
    .FILT_CYCLES(3),
    .PWRUP_CYCLES(40)
  ) dut_i (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .strap_i    (strap),
    .sda_oe_o   (sda_oe),
    .reg_wr_en_o(wr_en),
    .reg_addr_o (addr),
    .reg_wdata_o(wdata),
    .reg_rdata_i(rdata)
  );

  // bench register model: 00h and 10h exist, anything else reads 5Ah
  logic [7:0] wiper_r, ctrl_r;
  int wr_cnt = 0, bad_win = 0, r9_bad = 0;
  logic ack_win = 1'b0;
  logic prev_oe = 1'b0, prev_scl = 1'b1;

  always_comb begin
    case (addr)
      8'h00:   rdata = wiper_r;
      8'h10:   rdata = ctrl_r;
      default: rdata = 8'h5A;
    endcase
  end

  always @(posedge clk) begin
    if (rst) begin
      wiper_r <= 8'h80;
      ctrl_r  <= 8'h40;
    end else if (wr_en) begin
      wr_cnt <= wr_cnt + 1;
      if (!ack_win) bad_win <= bad_win + 1;
      if (addr == 8'h00) wiper_r <= wdata;
      if (addr == 8'h10) ctrl_r  <= wdata;
    end
    if (!rst && sda_oe != prev_oe && prev_scl) r9_bad <= r9_bad + 1;
    prev_oe  <= sda_oe;
    prev_scl <= m_scl;
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b1; hold(Q);
  endtask

  // acked = 1 when the slave pulled SDA low in the ninth clock
  task automatic send_byte(input logic [7:0] b, input bit glitch, input bit is_data, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      if (glitch && i == 3) begin
        hold(4); m_scl = 1'b1; hold(2); m_scl = 1'b0; hold(Q - 6);
      end else begin
        hold(Q);
      end
      m_scl = 1'b1; hold(2 * Q);
      m_scl = 1'b0; hold(Q);
    end
    m_sda = 1'b1; hold(Q);
    ack_win = is_data;
    m_scl = 1'b1; hold(Q);
    acked = ~sda_line;
    hold(Q);
    m_scl = 1'b0;
    ack_win = 1'b0;
    hold(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit host_ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; hold(Q);
      m_scl = 1'b1; hold(Q);
      b[i] = sda_line;
      hold(Q);
      m_scl = 1'b0; hold(Q);
    end
    m_sda = host_ack ? 1'b0 : 1'b1; hold(Q);
    m_scl = 1'b1; hold(2 * Q);
    m_scl = 1'b0; hold(Q);
  endtask

  function automatic logic [7:0] id_byte(input logic [1:0] s, input bit rd);
    return {5'b10100, s, rd};
  endfunction

  task automatic write_txn(input logic [7:0] a, input logic [7:0] d, input bit glitch, output bit [2:0] acks);
    bit k;
    bus_start;
    send_byte(id_byte(strap, 1'b0), 1'b0, 1'b0, k); acks[2] = k;
    send_byte(a, 1'b0, 1'b0, k);                    acks[1] = k;
    send_byte(d, glitch, 1'b1, k);                  acks[0] = k;
    bus_stop;
    hold(Q);
  endtask

  task automatic read_txn(input logic [7:0] a, input int n, input logic [7:0] exp, input string req);
    bit k;
    logic [7:0] b;
    bus_start;
    send_byte(id_byte(strap, 1'b0), 1'b0, 1'b0, k);
    chk(k, {req, " id write ack"}, {7'd0, k}, 8'd1);
    send_byte(a, 1'b0, 1'b0, k);
    chk(k, {req, " address ack"}, {7'd0, k}, 8'd1);
    bus_start;
    send_byte(id_byte(strap, 1'b1), 1'b0, 1'b0, k);
    chk(k, {req, " id read ack"}, {7'd0, k}, 8'd1);
    for (int j = 0; j < n; j++) begin
      recv_byte(b, j != n - 1);
      chk(b == exp, {req, " read data"}, b, exp);
    end
    hold(4);
    chk(sda_oe == 1'b0, {req, " SDA released after NACK"}, {7'd0, sda_oe}, 8'd0);
    bus_stop;
    hold(Q);
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R1 reset sda_oe", {7'd0, sda_oe}, 8'd0);
    chk(wr_en == 1'b0, "R1 reset wr_en", {7'd0, wr_en}, 8'd0);
  endtask

  task automatic t_powerup;
    bit k;
    bus_start;
    send_byte(id_byte(strap, 1'b0), 1'b0, 1'b0, k);
    chk(!k, "R1 start during power-up not acked", {7'd0, k}, 8'd0);
    send_byte(8'h00, 1'b0, 1'b0, k);
    send_byte(8'h11, 1'b0, 1'b1, k);
    bus_stop;
    hold(Q);
    chk(wiper_r == 8'h80 && wr_cnt == 0, "R1 no write during power-up", wiper_r, 8'h80);
  endtask

  task automatic t_write_wiper;
    bit [2:0] a;
    write_txn(8'h00, 8'h37, 1'b0, a);
    chk(a[2], "R3 id ack", {5'd0, a}, 8'h07);
    chk(a == 3'b111, "R5 write acks", {5'd0, a}, 8'h07);
    chk(wiper_r == 8'h37 && wr_cnt == 1, "R5 wiper written", wiper_r, 8'h37);
    chk(bad_win == 0, "R5 strobe in ninth clock", bad_win[7:0], 8'h00);
  endtask

  task automatic t_read_regs;
    read_txn(8'h00, 3, 8'h37, "R7 wiper repeated");
    read_txn(8'h10, 1, 8'h40, "R7 control default");
  endtask

  task automatic t_strap_variant;
    bit [2:0] a;
    strap = 2'b10;
    write_txn(8'h10, 8'hC3, 1'b0, a);
    chk(a == 3'b111, "R3 strap 10 acks", {5'd0, a}, 8'h07);
    chk(ctrl_r == 8'hC3, "R3 control written", ctrl_r, 8'hC3);
    read_txn(8'h10, 2, 8'hC3, "R3 strap 10 read");
  endtask

  task automatic t_bad_id;
    bit k1, k2, k3;
    int c0 = wr_cnt;
    bus_start;
    send_byte(id_byte(~strap, 1'b0), 1'b0, 1'b0, k1);
    send_byte(8'h00, 1'b0, 1'b0, k2);
    send_byte(8'hEE, 1'b0, 1'b1, k3);
    bus_stop;
    hold(Q);
    chk(!k1, "R4 mismatched id not acked", {7'd0, k1}, 8'd0);
    chk(!k2 && !k3, "R4 later bytes not acked", {6'd0, k2, k3}, 8'd0);
    chk(wr_cnt == c0 && wiper_r == 8'h37, "R4 no write", wiper_r, 8'h37);
    bus_start;
    send_byte(id_byte(8'h00 | strap, 1'b0), 1'b0, 1'b0, k1);
    bus_stop;
    hold(Q);
    chk(k1, "R4 next start acked again", {7'd0, k1}, 8'd1);
  endtask

  task automatic t_unmapped;
    bit [2:0] a;
    int c0 = wr_cnt;
    write_txn(8'h05, 8'h99, 1'b0, a);
    chk(a == 3'b111, "R6 unmapped write acked", {5'd0, a}, 8'h07);
    chk(wr_cnt == c0, "R6 no strobe for unmapped", 8'(wr_cnt - c0), 8'd0);
    read_txn(8'h05, 2, 8'h00, "R8 unmapped reads zero");
  endtask

  task automatic t_extra_byte;
    bit k;
    int c0;
    bus_start;
    send_byte(id_byte(strap, 1'b0), 1'b0, 1'b0, k);
    send_byte(8'h10, 1'b0, 1'b0, k);
    send_byte(8'h55, 1'b0, 1'b1, k);
    c0 = wr_cnt;
    send_byte(8'h66, 1'b0, 1'b0, k);
    bus_stop;
    hold(Q);
    chk(!k, "R11 extra byte not acked", {7'd0, k}, 8'd0);
    chk(ctrl_r == 8'h55 && wr_cnt == c0, "R11 extra byte not written", ctrl_r, 8'h55);
  endtask

  task automatic t_glitch;
    bit [2:0] a;
    write_txn(8'h00, 8'hA5, 1'b1, a);
    chk(a == 3'b111, "R2 acks with spike", {5'd0, a}, 8'h07);
    chk(wiper_r == 8'hA5, "R2 spike suppressed", wiper_r, 8'hA5);
  endtask

  task automatic t_after_stop;
    bit k;
    send_byte(id_byte(strap, 1'b0), 1'b0, 1'b0, k);
    chk(!k, "R10 byte after STOP not acked", {7'd0, k}, 8'd0);
    bus_stop;
    hold(Q);
    chk(sda_oe == 1'b0, "R10 idle released", {7'd0, sda_oe}, 8'd0);
  endtask

  bit done = 1'b0;

  initial begin
    hold(5);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_powerup;
    hold(100);
    t_write_wiper;
    t_read_regs;
    t_bad_id;
    t_unmapped;
    t_extra_byte;
    t_glitch;
    t_after_stop;
    t_strap_variant;
    chk(r9_bad == 0, "R9 SDA enable moved only with SCL low", r9_bad[7:0], 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%h expected=%h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule